// File: doc/BRIEF.md
# Masked Dual Alarm and Interrupt Unit

This block sits beside a real-time-clock counter and watches the current time. It holds two alarm setting groups. The first group compares seconds, minutes, hours and day-or-date. The second group compares minutes, hours and day-or-date, and it can only fire at second zero. Bit 7 of each alarm field is a mask bit. A masked field always counts as a match, so the masks give alarms that repeat every second, minute, hour, day or date. The match is checked only in the cycle of the 1 Hz strobe. A hit sets a sticky flag, and software clears the flag by writing 0 to it.

A control register decides what the shared open-drain pin carries. It can carry an active-low interrupt taken from the enabled flags, or one of four divided clock taps as a square wave. A third sticky flag records that the oscillator stopped. When the chip runs from backup power and the backup-enable bit is clear, the pin is released to high impedance.

Top module: `alarm_int_unit`

## Requirements
- R1: After reset, control reads 0x18, status reads 0x80, and every alarm register reads 0x00. The pin then carries the square wave from tap 3.
- R2: The register map is as follows:
  - Addresses 0..3 hold the first alarm group: seconds, minutes, hours, day/date.
  - Addresses 4..6 hold the second alarm group: minutes, hours, day/date.
  - Address 7 is control. Bit 6 of control always reads 0.
  - Address 8 is status: bit 7 oscillator-stop flag, bit 1 second-alarm flag, bit 0 first-alarm flag.
  - All other addresses read 0, and writes to them change nothing.
- R3: A first-group field matches when its bit 7 is 1 or when its bits 6:0 equal the current value. Seconds, minutes and hours each compare 7 bits. For the day/date field, bit 6 = 1 compares bits 5:0 with the day of week, and bit 6 = 0 compares them with the date. The group hits only when all four fields match.
- R4: The second group hits when its three fields match under the same rule and the current seconds equal 0.
- R5: A hit sets its flag on the clock edge where the 1 Hz strobe is high. A hit with no strobe never sets a flag.
- R6: Writing status clears each alarm flag whose data bit is 0 and keeps each flag whose data bit is 1. If a set and a clear fall on the same edge, the set wins.
- R7: The oscillator-stop flag is set while the stop input is high. Only a status write with bit 7 = 0 clears it.
- R8: When control bit 2 = 1, the pin is pulled low exactly while (flag0 & control bit 0) | (flag1 & control bit 1) is true.
- R9: When control bit 2 = 0, the pin is pulled low while the selected tap is low. Control bits 4:3 select the tap: 00 = tap 0 (1 Hz), 01 = tap 1, 10 = tap 2, 11 = tap 3 (32.768 kHz).
- R10: When running on backup with control bit 5 = 0, the pin floats and is never pulled low. With control bit 5 = 1, the pin behaves as in R8 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| secTick | input | 1 | One-cycle 1 Hz evaluation strobe |
| curSec | input | 7 | Current seconds, BCD |
| curMin | input | 7 | Current minutes, BCD |
| curHour | input | 7 | Current hours byte, bits 6:0 |
| curDay | input | 3 | Current day of week |
| curDate | input | 6 | Current date of month, BCD |
| oscStop | input | 1 | Oscillator-stopped indication |
| onBackup | input | 1 | Chip is running from backup power |
| sqTaps | input | 4 | Divided clock taps, tap 0 slowest |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| pinPullLow | output | 1 | Open-drain drive-low enable |
| pinFloat | output | 1 | Output stage released to high impedance |

## Verification
Two events can land on the same clock edge: an alarm hit during the 1 Hz strobe, and a software status write that clears the same flag. The bench provokes this by raising secTick together with a status write of zero while a group has every field masked. It expects the flag to read back as 1 afterward. A second write with no strobe must then clear the flag. Around this collision, the bench sweeps every mask pattern against a mismatch in each single field, and it checks the result arithmetically from the mask bits.

// File: rtl/alarmunit_pkg.sv
package alarmunit_pkg;
  localparam int DW        = 8;
  localparam int AW        = 4;
  localparam int NALM      = 7;
  localparam int IW        = $clog2(NALM);
  localparam int ADDR_CTRL = 7;
  localparam int ADDR_STAT = 8;
  localparam logic [DW-1:0] CTRL_RESET = 8'h18;
  localparam logic [DW-1:0] CTRL_MASK  = 8'hBF;

  typedef struct packed {
    logic [NALM-1:0] wrAlarm;
    logic            wrCtrl;
    logic            wrStat;
    logic            tick;
  } strobe_t;
endpackage

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarmunit_pkg::*;
(
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  input  logic          secTick,
  output strobe_t       strb
);
  always_comb begin
    strb = '0;
    strb.tick = secTick;
    if (regWe) begin
      for (int i = 0; i < NALM; i++)
        strb.wrAlarm[i] = (regAddr == AW'(i));
      strb.wrCtrl = (regAddr == AW'(ADDR_CTRL));
      strb.wrStat = (regAddr == AW'(ADDR_STAT));
    end
  end
endmodule

// File: rtl/alarm_dp.sv
module alarm_dp
  import alarmunit_pkg::*;
#(
  parameter int RS_W = 2,
  localparam int NTAPS = 1 << RS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [AW-1:0]    regAddr,
  input  logic [DW-1:0]    regWdata,
  input  logic [6:0]       curSec,
  input  logic [6:0]       curMin,
  input  logic [6:0]       curHour,
  input  logic [2:0]       curDay,
  input  logic [5:0]       curDate,
  input  logic             oscStop,
  input  logic             onBackup,
  input  logic [NTAPS-1:0] sqTaps,
  output logic [DW-1:0]    regRdata,
  output logic             pinPullLow,
  output logic             pinFloat
);
  logic [NALM-1:0][DW-1:0] almReg;
  logic [DW-1:0] ctrlReg;
  logic a1Flag, a2Flag, osfFlag;
  logic a1Hit, a2Hit, intActive, drive;
  logic [RS_W-1:0] rateSel;

  function automatic logic fieldEq(input logic [DW-1:0] r, input logic [6:0] cur);
    return r[7] | (r[6:0] == cur);
  endfunction

  function automatic logic dayDateEq(input logic [DW-1:0] r, input logic [2:0] d,
                                     input logic [5:0] dt);
    return r[7] | (r[6] ? (r[5:0] == {3'b000, d}) : (r[5:0] == dt));
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      almReg  <= '0;
      ctrlReg <= CTRL_RESET;
    end else begin
      for (int i = 0; i < NALM; i++)
        if (strb.wrAlarm[i]) almReg[i] <= regWdata;
      if (strb.wrCtrl) ctrlReg <= regWdata & CTRL_MASK;
    end
  end

  assign a1Hit = fieldEq(almReg[0], curSec) & fieldEq(almReg[1], curMin) &
                 fieldEq(almReg[2], curHour) & dayDateEq(almReg[3], curDay, curDate);
  assign a2Hit = (curSec == 7'd0) & fieldEq(almReg[4], curMin) &
                 fieldEq(almReg[5], curHour) & dayDateEq(almReg[6], curDay, curDate);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      a1Flag  <= 1'b0;
      a2Flag  <= 1'b0;
      osfFlag <= 1'b1;
    end else begin
      if (strb.tick && a1Hit)             a1Flag <= 1'b1;
      else if (strb.wrStat && !regWdata[0]) a1Flag <= 1'b0;
      if (strb.tick && a2Hit)             a2Flag <= 1'b1;
      else if (strb.wrStat && !regWdata[1]) a2Flag <= 1'b0;
      if (oscStop)                        osfFlag <= 1'b1;
      else if (strb.wrStat && !regWdata[7]) osfFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr < AW'(NALM))          regRdata = almReg[regAddr[IW-1:0]];
    else if (regAddr == AW'(ADDR_CTRL)) regRdata = ctrlReg;
    else if (regAddr == AW'(ADDR_STAT)) regRdata = {osfFlag, 5'b00000, a2Flag, a1Flag};
  end

  assign rateSel    = ctrlReg[3 +: RS_W];
  assign intActive  = (a1Flag & ctrlReg[0]) | (a2Flag & ctrlReg[1]);
  assign drive      = ctrlReg[2] ? intActive : ~sqTaps[rateSel];
  assign pinFloat   = onBackup & ~ctrlReg[5];
  assign pinPullLow = drive & ~pinFloat;

  a_r5_a1_sets: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && a1Hit) |=> a1Flag);
  a_r5_a2_sets: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && a2Hit) |=> a2Flag);
  a_r5_no_tick_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (!a1Flag && !strb.tick) |=> !a1Flag);
  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (a1Flag && !strb.wrStat) |=> a1Flag);
  a_r7_osf_sets: assert property (@(posedge clk) disable iff (!rstN)
    oscStop |=> osfFlag);
  a_r10_backup_release: assert property (@(posedge clk) disable iff (!rstN)
    (onBackup && !ctrlReg[5]) |-> (pinFloat && !pinPullLow));
endmodule

// File: rtl/alarm_int_unit.sv
module alarm_int_unit
  import alarmunit_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          secTick,
  input  logic [6:0]    curSec,
  input  logic [6:0]    curMin,
  input  logic [6:0]    curHour,
  input  logic [2:0]    curDay,
  input  logic [5:0]    curDate,
  input  logic          oscStop,
  input  logic          onBackup,
  input  logic [3:0]    sqTaps,
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  output logic          pinPullLow,
  output logic          pinFloat
);
  strobe_t strb;

  alarm_ctrl u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .secTick(secTick), .strb(strb)
  );

  alarm_dp #(.RS_W(2)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr), .regWdata(regWdata),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDay(curDay),
    .curDate(curDate), .oscStop(oscStop), .onBackup(onBackup), .sqTaps(sqTaps),
    .regRdata(regRdata), .pinPullLow(pinPullLow), .pinFloat(pinFloat)
  );
endmodule

// File: tb/alarm_int_unit_test.sv
module alarm_int_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0, secTick = 0, oscStop = 0, onBackup = 0, regWe = 0;
  logic [6:0] curSec = 0, curMin = 0, curHour = 0;
  logic [2:0] curDay = 0;
  logic [5:0] curDate = 0;
  logic [3:0] sqTaps = 0, regAddr = 0;
  logic [7:0] regWdata = 0, regRdata;
  logic pinPullLow, pinFloat;
  int nTests = 0, nFail = 0;
  bit done = 0;

  alarm_int_unit uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic tick();
    @(negedge clk); secTick = 1;
    @(negedge clk); secTick = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    sqTaps = 4'b0111;
    #(CLK_PERIOD * 3); @(negedge clk); rstN = 1;
    // R1 reset state
    rd(7, d); check("R1 ctrl", d, 8'h18);
    rd(8, d); check("R1 status", d, 8'h80);
    for (int i = 0; i < 7; i++) begin rd(4'(i), d); check("R1 alarm reg", d, 0); end
    #1 check("R1 pin tap3 low", pinPullLow, 1);
    // R2 map
    for (int i = 0; i < 7; i++) wr(4'(i), 8'hA0 + 8'(i));
    for (int i = 0; i < 7; i++) begin rd(4'(i), d); check("R2 alarm rw", d, 8'hA0 + 8'(i)); end
    wr(7, 8'hFF); rd(7, d); check("R2 ctrl bit6", d, 8'hBF);
    wr(12, 8'h00); rd(7, d); check("R2 unused write", d, 8'hBF);
    rd(9, d); check("R2 unused read", d, 0);
    wr(7, 8'h18);
    // R7 oscillator-stop flag
    wr(8, 8'h7F); rd(8, d); check("R7 osf cleared", d, 0);
    @(negedge clk); oscStop = 1; @(negedge clk); oscStop = 0;
    rd(8, d); check("R7 osf set", d, 8'h80);
    wr(8, 8'h80); rd(8, d); check("R7 osf kept", d, 8'h80);
    wr(8, 8'h00);
    // R3/R5 first group: every mask pattern against each single-field mismatch
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 5; v++) begin
        bit exp;
        wr(0, {m[0], 7'h30}); wr(1, {m[1], 7'h15});
        wr(2, {m[2], 7'h12}); wr(3, {m[3], 7'h14});
        curSec = (v == 1) ? 7'h31 : 7'h30; curMin = (v == 2) ? 7'h16 : 7'h15;
        curHour = (v == 3) ? 7'h13 : 7'h12; curDate = (v == 4) ? 6'h15 : 6'h14;
        curDay = 3;
        exp = (v == 0) || m[v-1];
        tick(); rd(8, d); check("R3 R5 group1 sweep", d[0], exp);
        wr(8, 8'h00);
      end
    end
    // R3 day-of-week select
    wr(3, 8'h43); curDate = 6'h01; curDay = 3;
    tick(); rd(8, d); check("R3 day select hit", d[0], 1); wr(8, 0);
    curDay = 4; tick(); rd(8, d); check("R3 day select miss", d[0], 0);
    // R5 no strobe
    curDay = 3; repeat (3) @(negedge clk);
    rd(8, d); check("R5 no strobe", d[0], 0);
    // R4 second group sweep
    for (int m = 0; m < 8; m++) begin
      for (int v = 0; v < 5; v++) begin
        bit exp;
        wr(4, {m[0], 7'h15}); wr(5, {m[1], 7'h12}); wr(6, {m[2], 7'h43});
        curSec = (v == 1) ? 7'h01 : 7'h00; curMin = (v == 2) ? 7'h16 : 7'h15;
        curHour = (v == 3) ? 7'h13 : 7'h12; curDay = (v == 4) ? 3'd4 : 3'd3;
        exp = (v != 1) && ((v == 0) || m[v-2]);
        tick(); rd(8, d); check("R4 group2 sweep", d[1], exp);
        wr(8, 8'h00);
      end
    end
    // R6 write semantics and same-edge collision
    for (int i = 0; i < 4; i++) wr(4'(i), 8'h80);
    curSec = 7'h05;
    tick(); wr(8, 8'h01); rd(8, d); check("R6 write1 keeps", d[0], 1);
    wr(8, 8'h00); rd(8, d); check("R6 write0 clears", d[0], 0);
    @(negedge clk); secTick = 1; regWe = 1; regAddr = 8; regWdata = 8'h00;
    @(negedge clk); secTick = 0; regWe = 0;
    rd(8, d); check("R6 set beats clear", d[0], 1);
    wr(8, 8'h00); rd(8, d); check("R6 clear after collision", d[0], 0);
    // R8 interrupt sweep
    for (int i = 4; i < 7; i++) wr(4'(i), 8'h80);
    curSec = 0;
    for (int f = 0; f < 4; f++) begin
      for (int ie = 0; ie < 4; ie++) begin
        wr(7, 8'h04 | 8'(ie));
        tick(); wr(8, {6'b0, 2'(f)});
        #1 check("R8 interrupt", pinPullLow, |(2'(f) & 2'(ie)));
        check("R8 not floating", pinFloat, 0);
      end
    end
    // R9 square-wave select sweep
    for (int rs = 0; rs < 4; rs++) begin
      wr(7, 8'(rs << 3));
      for (int t = 0; t < 16; t++) begin
        @(negedge clk); sqTaps = 4'(t); #1
        check("R9 square wave", pinPullLow, !t[rs]);
      end
    end
    // R10 backup release
    tick(); wr(7, 8'h07);
    @(negedge clk); onBackup = 1; #1
    check("R10 float", pinFloat, 1); check("R10 released", pinPullLow, 0);
    wr(7, 8'h27); #1
    check("R10 enabled on backup", pinFloat, 0); check("R10 int drives", pinPullLow, 1);
    finishRun();
  end
endmodule